// File: doc/BRIEF.md
# Audio Serial Bit-Clock Prescaler

This block derives the serial bit clock of an audio serial-bus master from a faster reference clock. The division ratio is given as a half-divider field and one extra bit that makes the ratio odd. The total ratio is twice the field plus that bit. Odd ratios keep the duty cycle as close to even as one reference cycle allows. The idle level of the bit clock is selectable. A separate gate lets a master clock output run at a fixed fraction of the reference.

A single enable starts and stops everything. While the enable is low the configuration inputs are copied into shadow flops. While it is high they are frozen, so a setting change made in the middle of a run never reaches the clock. A one-cycle bit strobe marks each bit-clock edge at which serial data should change, and the word-select and shift logic downstream advance on it.

Top module: `aud_sck_prescaler`

## Requirements
- R1: While rst_ni is low, sck_o, mck_o and bit_stb_o are all 0.
- R2: While enabled, sck_o alternates between two phases. The drive phase, at the level opposite to idle, lasts half+odd reference cycles. The rest phase, at the idle level, lasts half cycles. The full period is therefore 2*half+odd cycles.
- R3: The idle level is taken from idle_high_i: 0 means sck_o idles low and 1 means it idles high. The drive phase is at the inverted level.
- R4: A half_div_i value below 2 (that is 0 or 1) is treated as 2. Every value from 2 to 255 is used as given.
- R5: When enable_i was low at the previous clock edge, sck_o equals the idle_high_i sampled at that edge, and mck_o and bit_stb_o are 0.
- R6: At the first clock edge that samples enable_i high after a low, sck_o leaves the idle level and a drive phase starts.
- R7: bit_stb_o is high for exactly one reference cycle. It is high in the first cycle of each rest phase, that is right after every drive-to-rest edge of sck_o, and never at any other time.
- R8: With the shadowed master-clock gate set, mck_o starts at 0 on the enabling edge and then toggles every MCK_HALF reference cycles. With the gate clear, mck_o stays 0.
- R9: Changes to half_div_i, odd_i, idle_high_i and mck_en_i while enable_i is high do not affect sck_o or mck_o. They take effect at the next enable.
- R10: The clock edge that samples enable_i low returns sck_o to idle and forces mck_o and bit_stb_o to 0, wherever in the phase it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable; configuration is shadowed while low |
| half_div_i | input | HALF_W | Half-divider field, clamped to at least 2 |
| odd_i | input | 1 | Adds one reference cycle to the period |
| mck_en_i | input | 1 | Master clock output gate |
| idle_high_i | input | 1 | Bit clock idle level (1 = high) |
| sck_o | output | 1 | Serial bit clock |
| mck_o | output | 1 | Master clock |
| bit_stb_o | output | 1 | One-cycle strobe at each data-change edge of sck_o |

## Verification
The bench runs the divider with an even ratio, an odd ratio and an odd ratio with high idle level. It also runs ratio fields of 0 and 1 and the largest field with odd set. Even against odd shows whether the extra cycle lands in the drive phase and not in the rest phase. The two polarities show that the drive phase follows the inverted idle level rather than a fixed high. The clamp cases and the maximum case probe both ends of the counter limit. One run changes every configuration input right after start, and the next run shows that the new values apply only after re-enabling. Each run ends by dropping enable partway through a phase, and this shows whether the stop is immediate.

// File: rtl/aud_sck_pkg.sv
package aud_sck_pkg;

  typedef enum logic {
    PH_REST  = 1'b0,
    PH_DRIVE = 1'b1
  } phase_e;

  function automatic int unsigned clamp_half(input int unsigned v,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/aud_cfg_shadow.sv
module aud_cfg_shadow #(
  parameter int HALF_W   = 8,
  parameter int HALF_MIN = 2,
  parameter int HALF_MAX = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              odd_i,
  input  logic              mck_en_i,
  input  logic              idle_high_i,
  output logic [HALF_W-1:0] half_o,
  output logic              odd_o,
  output logic              mck_en_o,
  output logic              idle_high_o
);
  logic [HALF_W-1:0] half_cl;

  assign half_cl = HALF_W'(aud_sck_pkg::clamp_half(32'(half_i), HALF_MIN, HALF_MAX));

  // shadow follows inputs only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o      <= HALF_W'(HALF_MIN);
      odd_o       <= 1'b0;
      mck_en_o    <= 1'b0;
      idle_high_o <= 1'b0;
    end else if (load_i) begin
      half_o      <= half_cl;
      odd_o       <= odd_i;
      mck_en_o    <= mck_en_i;
      idle_high_o <= idle_high_i;
    end
  end
endmodule

// File: rtl/aud_sck_gen.sv
module aud_sck_gen #(
  parameter int HALF_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [HALF_W-1:0]       half_i,
  input  logic                    odd_i,
  output aud_sck_pkg::phase_e     phase_o,
  output logic                    running_o,
  output logic                    stb_o
);
  import aud_sck_pkg::*;

  localparam int CNT_W = HALF_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             last;
  phase_e           phase_q;
  logic             run_q;
  logic             stb_q;

  always_comb begin
    lim  = (phase_q == PH_DRIVE) ? ({1'b0, half_i} + CNT_W'(odd_i)) : {1'b0, half_i};
    last = (cnt_q == lim - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_REST;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!run_i) begin
        run_q   <= 1'b0;
        phase_q <= PH_REST;
        cnt_q   <= '0;
      end else if (!run_q) begin
        run_q   <= 1'b1;
        phase_q <= PH_DRIVE;
        cnt_q   <= '0;
      end else if (last) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_DRIVE) ? PH_REST : PH_DRIVE;
        stb_q   <= (phase_q == PH_DRIVE);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase_o   = phase_q;
  assign running_o = run_q;
  assign stb_o     = stb_q;
endmodule

// File: rtl/aud_mck_gen.sv
module aud_mck_gen #(
  parameter int MCK_HALF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mck_o
);
  logic mck_q;

  if (MCK_HALF <= 1) begin : g_div2
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mck_q <= 1'b0;
      else if (!run_i) mck_q <= 1'b0;
      else             mck_q <= ~mck_q;
    end
  end else begin : g_divn
    localparam int MCW = $clog2(MCK_HALF);
    logic [MCW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mck_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_i) begin
        mck_q <= 1'b0;
        cnt_q <= '0;
      end else if (cnt_q == MCW'(MCK_HALF - 1)) begin
        mck_q <= ~mck_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + MCW'(1);
      end
    end
  end

  assign mck_o = mck_q;
endmodule

// File: rtl/aud_sck_prescaler.sv
module aud_sck_prescaler #(
  parameter int HALF_W   = 8,
  parameter int HALF_MIN = 2,
  parameter int MCK_HALF = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [HALF_W-1:0] half_div_i,
  input  logic              odd_i,
  input  logic              mck_en_i,
  input  logic              idle_high_i,
  output logic              sck_o,
  output logic              mck_o,
  output logic              bit_stb_o
);
  import aud_sck_pkg::*;

  localparam int HALF_MAX = (1 << HALF_W) - 1;

  logic [HALF_W-1:0] half_s;
  logic              odd_s;
  logic              mck_en_s;
  logic              idle_high_s;
  phase_e            phase;
  logic              running;
  logic              stb;

  aud_cfg_shadow #(
    .HALF_W  (HALF_W),
    .HALF_MIN(HALF_MIN),
    .HALF_MAX(HALF_MAX)
  ) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (!enable_i),
    .half_i     (half_div_i),
    .odd_i      (odd_i),
    .mck_en_i   (mck_en_i),
    .idle_high_i(idle_high_i),
    .half_o     (half_s),
    .odd_o      (odd_s),
    .mck_en_o   (mck_en_s),
    .idle_high_o(idle_high_s)
  );

  aud_sck_gen #(
    .HALF_W(HALF_W)
  ) i_sck (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (enable_i),
    .half_i   (half_s),
    .odd_i    (odd_s),
    .phase_o  (phase),
    .running_o(running),
    .stb_o    (stb)
  );

  aud_mck_gen #(
    .MCK_HALF(MCK_HALF)
  ) i_mck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (enable_i && running && mck_en_s),
    .mck_o (mck_o)
  );

  assign sck_o     = (phase == PH_DRIVE) ^ idle_high_s;
  assign bit_stb_o = stb;
endmodule

// File: rtl/aud_sck_prescaler_chk.sv
module aud_sck_prescaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic idle_high_i,
  input logic sck_o,
  input logic mck_o,
  input logic bit_stb_o
);
  logic [1:0] seen_q;
  logic       seen_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 2'd0;
    else if (seen_q != 2'd2)  seen_q <= seen_q + 2'd1;
  end
  assign seen_ok = (seen_q == 2'd2);

  // R5 R10
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_ok && !enable_i) |=> (sck_o == $past(idle_high_i)) && !mck_o && !bit_stb_o);

  // R6
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_ok && enable_i && !$past(enable_i)) |=> (sck_o != $past(sck_o)));

  // R7
  stb_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_ok && bit_stb_o) |-> (sck_o != $past(sck_o)));

  // R7
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (!mck_o && !bit_stb_o);
    end
  end
endmodule

bind aud_sck_prescaler aud_sck_prescaler_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .idle_high_i(idle_high_i),
  .sck_o      (sck_o),
  .mck_o      (mck_o),
  .bit_stb_o  (bit_stb_o)
);

// File: tb/test_aud_sck_prescaler.sv
module test_aud_sck_prescaler;
  localparam int HALF_W = 8;
  localparam int MCKH   = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic [HALF_W-1:0] half_div_i = '0;
  logic              odd_i = 1'b0;
  logic              mck_en_i = 1'b0;
  logic              idle_high_i = 1'b0;
  logic              sck_o;
  logic              mck_o;
  logic              bit_stb_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk_i = ~clk_i;

  aud_sck_prescaler #(
    .HALF_W  (HALF_W),
    .HALF_MIN(2),
    .MCK_HALF(MCKH)
  ) i_aud_sck_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .half_div_i (half_div_i),
    .odd_i      (odd_i),
    .mck_en_i   (mck_en_i),
    .idle_high_i(idle_high_i),
    .sck_o      (sck_o),
    .mck_o      (mck_o),
    .bit_stb_o  (bit_stb_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(sck_o == 1'b0, "R1", "sck in reset", int'(sck_o), 0);
    check(!mck_o && !bit_stb_o, "R1", "mck/strobe in reset", int'({mck_o, bit_stb_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // one enable/run/disable cycle with expected timing from the given setting
  task automatic run_case(input int h, input int o, input bit pol, input bit men,
                          input bit do_chg, input string req);
    int hc, exp_hi, exp_lo, ncyc;
    int prev_act, act, run_len, first, exp_m;
    int bad_hi, bad_lo, bad_stb, bad_mck, n_hi, n_lo;
    hc     = (h < 2) ? 2 : h;
    exp_hi = hc + o;
    exp_lo = hc;
    ncyc   = 3 * (exp_hi + exp_lo) + 3;
    @(negedge clk_i);
    enable_i    = 1'b0;
    half_div_i  = h[HALF_W-1:0];
    odd_i       = o[0];
    idle_high_i = pol;
    mck_en_i    = men;
    repeat (3) @(negedge clk_i);
    check(sck_o == pol, "R3", "idle sck level", int'(sck_o), int'(pol));
    check(!mck_o && !bit_stb_o, "R5", "mck/strobe while disabled", int'({mck_o, bit_stb_o}), 0);
    enable_i = 1'b1;
    prev_act = 0; run_len = 0; first = 0;
    bad_hi = 0; bad_lo = 0; bad_stb = 0; bad_mck = 0; n_hi = 0; n_lo = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk_i);
      act = int'(sck_o ^ pol);
      if (i == 0) first = act;
      if (act == prev_act) run_len++;
      else begin
        if (i > 0) begin
          if (prev_act == 1) begin n_hi++; if (run_len != exp_hi) bad_hi++; end
          else begin n_lo++; if (run_len != exp_lo) bad_lo++; end
        end
        run_len = 1;
      end
      if (int'(bit_stb_o) != int'(prev_act == 1 && act == 0 && i > 0)) bad_stb++;
      exp_m = men ? ((i / MCKH) % 2) : 0;
      if (int'(mck_o) != exp_m) bad_mck++;
      prev_act = act;
      if (do_chg && i == 0) begin
        half_div_i  = 8'd9;
        odd_i       = ~odd_i;
        idle_high_i = ~pol;
        mck_en_i    = ~men;
      end
    end
    check(first == 1, "R6", "drive phase at start", first, 1);
    check(n_hi > 0 && bad_hi == 0, req, "drive phase length errors (R2)", bad_hi, 0);
    check(n_lo > 0 && bad_lo == 0, req, "rest phase length errors (R2)", bad_lo, 0);
    check(bad_stb == 0, "R7", "strobe misalignments", bad_stb, 0);
    check(bad_mck == 0, "R8", "mck sequence errors", bad_mck, 0);
    enable_i = 1'b0;
    @(negedge clk_i);
    check(sck_o == idle_high_i, "R10", "sck idle after stop", int'(sck_o), int'(idle_high_i));
    check(!mck_o && !bit_stb_o, "R10", "mck/strobe after stop", int'({mck_o, bit_stb_o}), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    run_case(4,   0, 1'b0, 1'b1, 1'b0, "R2");
    run_case(5,   1, 1'b0, 1'b0, 1'b0, "R2");
    run_case(3,   1, 1'b1, 1'b1, 1'b0, "R3");
    run_case(0,   0, 1'b0, 1'b1, 1'b0, "R4");
    run_case(1,   1, 1'b1, 1'b0, 1'b0, "R4");
    run_case(255, 1, 1'b0, 1'b1, 1'b0, "R4");
    run_case(3,   0, 1'b0, 1'b1, 1'b1, "R9");
    run_case(9,   1, 1'b1, 1'b0, 1'b0, "R9");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule